// File: doc/BRIEF.md
# Serial Configuration Port with Register Bank

This block is a serial configuration slave for a small bank of 8-bit registers behind a 13-bit address field. An external master selects it with an active-low chip select, clocks it with a serial clock, and exchanges bits over one shared data line. An optional dedicated output line can carry read data instead. Each transaction opens with a 16-bit header that holds the direction, a length code and a start address. One or more data bytes follow, and the address steps once per byte.

A control register at address 0 picks the bit order (MSB-first or LSB-first) and whether read data leaves on the shared line (3-wire) or on the dedicated output (4-wire). The port latches both settings when a transaction starts, so a change applies from the next transaction. The master may raise chip select for a while between bytes. The length code decides whether the transfer resumes or is dropped. All serial inputs are oversampled in the system clock domain. The shared line appears as separate input, output and output-enable ports for the pad ring.

Top module: `spi_cfg_port`

## Requirements
- R1: After reset the control register reads 0x00 (MSB-first, 3-wire), every bank register reads 0x00, and the shared line is not driven.
- R2: In MSB-first order the first header bit is header bit 15. Header bit 15 is the direction (1 read, 0 write), bits 14:13 are the length code (00 one byte, 01 two, 10 three, 11 stream until chip select rises), and bits 12:0 are the start address. The bank registers sit at addresses 1 to 8.
- R3: Read data is launched on falling serial clock edges, beginning with the fall after the 16th header bit, and the master samples it at the next rising edge. In 3-wire mode the output enable is high only while read data is driven. It is low during the header, during writes, and after chip select rises.
- R4: Control bit 6 set selects LSB-first order. The header is then sent starting with bit 0, and data bytes are sent and received starting with bit 0.
- R5: After each data byte the address goes up by one in MSB-first order and down by one in LSB-first order.
- R6: Control bit 7 set selects 4-wire mode. Read data then appears on the dedicated output, and the shared line's output enable stays low.
- R7: A fixed length code moves exactly that many bytes. A register just past the last one is left unchanged.
- R8: For length codes 00 to 10, chip select may go high at any byte boundary, and the transfer then resumes where it left off, for both reads and writes.
- R9: With length code 11, chip select may go high inside the header or before the first data byte without losing state. Chip select high after a data byte has completed ends the transfer, and later bits start a new header.
- R10: Chip select high in the middle of a data byte ends the transfer, and the partial byte is not written.
- R11: Writes to addresses outside 0 to 8 are ignored, and reads from them return 0x00. Control bits 5:0 always read as 0.
- R12: A control write takes effect from the next transaction. The rest of the same transaction keeps the bit order and stepping direction it started with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to oversample the serial pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock from the master |
| cs_ni | input | 1 | Chip select, active low |
| sdio_i | input | 1 | Shared data line, input side |
| sdio_o | output | 1 | Shared data line, output side |
| sdio_oe_o | output | 1 | Output enable for the shared data line |
| sdo_o | output | 1 | Dedicated serial output used in 4-wire mode |

## Verification
The assertions assume that the serial clock and chip select change slowly compared with the system clock, so that each pin level lasts several system cycles and every edge is seen exactly once after synchronization. They also assume that chip select changes only while the serial clock is low. The bench holds each serial clock phase for eight system cycles and waits ten cycles after every chip-select change. It moves chip select only with the serial clock low, so the edges it creates always fall inside these assumptions.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;
  localparam int ADDR_W     = 13;
  localparam int HDR_W      = 16;
  localparam int BYTE_W     = 8;
  localparam int CTRL_W4    = 7;
  localparam int CTRL_LSB   = 6;
  localparam logic [1:0] LEN_STREAM = 2'b11;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_HDR,
    ST_DATA
  } st_e;
endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic sdi_i,
  output logic sclk_rise_o,
  output logic sclk_fall_o,
  output logic cs_n_o,
  output logic sdi_o
);
  logic [STAGES-1:0] sclk_p, cs_p, sd_p;
  logic sclk_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_p <= '0;
      cs_p   <= '1;
      sd_p   <= '0;
      sclk_d <= 1'b0;
    end else begin
      sclk_p <= {sclk_p[STAGES-2:0], sclk_i};
      cs_p   <= {cs_p[STAGES-2:0], cs_ni};
      sd_p   <= {sd_p[STAGES-2:0], sdi_i};
      sclk_d <= sclk_p[STAGES-1];
    end
  end

  assign sclk_rise_o = sclk_p[STAGES-1] & ~sclk_d;
  assign sclk_fall_o = ~sclk_p[STAGES-1] & sclk_d;
  assign cs_n_o      = cs_p[STAGES-1];
  assign sdi_o       = sd_p[STAGES-1];
endmodule

// File: rtl/spi_cfg_regfile.sv
module spi_cfg_regfile import spi_cfg_pkg::*; #(
  parameter int N_GP    = 8,
  parameter int GP_BASE = 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              lsb_o,
  output logic              w4_o
);
  logic [N_GP*BYTE_W-1:0] gp_flat;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lsb_o <= 1'b0;
      w4_o  <= 1'b0;
    end else if (we_i && waddr_i == '0) begin
      lsb_o <= wdata_i[CTRL_LSB];
      w4_o  <= wdata_i[CTRL_W4];
    end
  end

  for (genvar g = 0; g < N_GP; g++) begin : g_gp
    localparam logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(GP_BASE + g);
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          q <= '0;
      else if (we_i && waddr_i == REG_ADDR) q <= wdata_i;
    end
    assign gp_flat[g*BYTE_W +: BYTE_W] = q;
  end

  always_comb begin
    rdata_o = '0;
    if (raddr_i == '0) begin
      rdata_o[CTRL_W4]  = w4_o;
      rdata_o[CTRL_LSB] = lsb_o;
    end
    for (int i = 0; i < N_GP; i++)
      if (raddr_i == ADDR_W'(GP_BASE + i)) rdata_o = gp_flat[i*BYTE_W +: BYTE_W];
  end
endmodule

// File: rtl/spi_cfg_port.sv
module spi_cfg_port import spi_cfg_pkg::*; #(
  parameter int N_GP        = 8,
  parameter int GP_BASE     = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sclk_i,
  input  logic cs_ni,
  input  logic sdio_i,
  output logic sdio_o,
  output logic sdio_oe_o,
  output logic sdo_o
);
  localparam int HCNT_W = $clog2(HDR_W);
  localparam int BCNT_W = $clog2(BYTE_W);

  logic sclk_rise, sclk_fall, cs_s, din_s;
  st_e  state_q;
  logic [HDR_W-1:0]  hdr_q, hdr_nxt;
  logic [HCNT_W-1:0] hcnt_q;
  logic [BCNT_W-1:0] bcnt_q;
  logic [1:0]        len_q, nbytes_q;
  logic [ADDR_W-1:0] addr_q, addr_step, raddr;
  logic [BYTE_W-1:0] rx_q, rx_nxt, tx_q, rdata;
  logic rw_q, lsb_q, w4_q, sdo_q, drive_q;
  logic ctrl_lsb, ctrl_w4, lsb_cur;
  logic hdr_end, byte_end, last_byte, pause_ok, we;

  spi_cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .sclk_i, .cs_ni, .sdi_i(sdio_i),
    .sclk_rise_o(sclk_rise), .sclk_fall_o(sclk_fall), .cs_n_o(cs_s), .sdi_o(din_s)
  );

  // bit order for the header is taken from the control reg on the opening edge
  assign lsb_cur   = (state_q == ST_IDLE) ? ctrl_lsb : lsb_q;
  assign hdr_nxt   = lsb_cur ? {din_s, hdr_q[HDR_W-1:1]} : {hdr_q[HDR_W-2:0], din_s};
  assign rx_nxt    = lsb_q ? {din_s, rx_q[BYTE_W-1:1]} : {rx_q[BYTE_W-2:0], din_s};
  assign addr_step = lsb_q ? addr_q - 1'b1 : addr_q + 1'b1;
  assign hdr_end   = (state_q == ST_HDR) && sclk_rise && !cs_s && (hcnt_q == HCNT_W'(HDR_W-1));
  assign byte_end  = (state_q == ST_DATA) && sclk_rise && !cs_s && (bcnt_q == BCNT_W'(BYTE_W-1));
  assign last_byte = (len_q != LEN_STREAM) && (nbytes_q == len_q);
  assign pause_ok  = (state_q == ST_HDR) ||
                     ((state_q == ST_DATA) && bcnt_q == '0 &&
                      (nbytes_q == '0 || len_q != LEN_STREAM));
  assign raddr     = hdr_end ? hdr_nxt[ADDR_W-1:0] : addr_step;
  assign we        = byte_end && !rw_q;

  spi_cfg_regfile #(.N_GP(N_GP), .GP_BASE(GP_BASE)) u_regs (
    .clk_i, .rst_ni,
    .we_i(we), .waddr_i(addr_q), .wdata_i(rx_nxt),
    .raddr_i(raddr), .rdata_o(rdata),
    .lsb_o(ctrl_lsb), .w4_o(ctrl_w4)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      hdr_q    <= '0;
      hcnt_q   <= '0;
      bcnt_q   <= '0;
      len_q    <= '0;
      nbytes_q <= '0;
      addr_q   <= '0;
      rx_q     <= '0;
      tx_q     <= '0;
      rw_q     <= 1'b0;
      lsb_q    <= 1'b0;
      w4_q     <= 1'b0;
      sdo_q    <= 1'b0;
    end else if (cs_s) begin
      if (state_q != ST_IDLE && !pause_ok) state_q <= ST_IDLE;
    end else if (sclk_rise) begin
      unique case (state_q)
        ST_IDLE: begin
          lsb_q   <= ctrl_lsb;
          w4_q    <= ctrl_w4;
          hdr_q   <= hdr_nxt;
          hcnt_q  <= HCNT_W'(1);
          state_q <= ST_HDR;
        end
        ST_HDR: begin
          hdr_q  <= hdr_nxt;
          hcnt_q <= hcnt_q + 1'b1;
          if (hdr_end) begin
            rw_q     <= hdr_nxt[HDR_W-1];
            len_q    <= hdr_nxt[HDR_W-2 -: 2];
            addr_q   <= hdr_nxt[ADDR_W-1:0];
            bcnt_q   <= '0;
            nbytes_q <= '0;
            tx_q     <= rdata;
            state_q  <= ST_DATA;
          end
        end
        ST_DATA: begin
          rx_q   <= rx_nxt;
          bcnt_q <= bcnt_q + 1'b1;
          if (byte_end) begin
            addr_q   <= addr_step;
            nbytes_q <= (nbytes_q == 2'd3) ? 2'd3 : nbytes_q + 1'b1;
            tx_q     <= rdata;  // prefetch next byte
            if (last_byte) state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end else if (sclk_fall && state_q == ST_DATA && rw_q) begin
      sdo_q <= lsb_q ? tx_q[0] : tx_q[BYTE_W-1];
      tx_q  <= lsb_q ? {1'b0, tx_q[BYTE_W-1:1]} : {tx_q[BYTE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                          drive_q <= 1'b0;
    else if (cs_s || state_q == ST_IDLE)                  drive_q <= 1'b0;
    else if (sclk_fall && state_q == ST_DATA && rw_q)     drive_q <= 1'b1;
  end

  assign sdio_o    = w4_q ? 1'b0 : sdo_q;
  assign sdio_oe_o = drive_q & ~w4_q;
  assign sdo_o     = w4_q ? sdo_q : 1'b0;
endmodule

// File: rtl/spi_cfg_port_chk.sv
module spi_cfg_port_chk import spi_cfg_pkg::*; (
  input logic              clk_i,
  input logic              rst_ni,
  input st_e               state_q,
  input logic              cs_s,
  input logic              sclk_fall,
  input logic              byte_end,
  input logic              rw_q,
  input logic              lsb_q,
  input logic              w4_q,
  input logic              sdo_q,
  input logic [2:0]        bcnt_q,
  input logic [1:0]        len_q,
  input logic [1:0]        nbytes_q,
  input logic [ADDR_W-1:0] addr_q,
  input logic              sdio_oe_o
);
  p_cs_release_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_s |=> !sdio_oe_o);

  p_write_quiet_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && !rw_q) |-> !sdio_oe_o);

  p_sdo_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sclk_fall |=> $stable(sdo_q));

  p_step_up_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_end && !lsb_q) |=> addr_q == $past(addr_q) + 1'b1);

  p_step_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (byte_end && lsb_q) |=> addr_q == $past(addr_q) - 1'b1);

  p_four_wire_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    w4_q |-> !sdio_oe_o);

  p_stream_abort_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && cs_s && len_q == LEN_STREAM && nbytes_q != 2'd0) |=> state_q == ST_IDLE);

  p_midbyte_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_DATA && cs_s && bcnt_q != 3'd0) |=> state_q == ST_IDLE);
endmodule

bind spi_cfg_port spi_cfg_port_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .state_q(state_q), .cs_s(cs_s),
  .sclk_fall(sclk_fall), .byte_end(byte_end), .rw_q(rw_q), .lsb_q(lsb_q),
  .w4_q(w4_q), .sdo_q(sdo_q), .bcnt_q(bcnt_q), .len_q(len_q),
  .nbytes_q(nbytes_q), .addr_q(addr_q), .sdio_oe_o(sdio_oe_o)
);

// File: tb/spi_cfg_port_tb.sv
`timescale 1ns/1ps
module spi_cfg_port_tb;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, cs_n = 1'b1, sdin = 1'b0;
  logic sdio_o, sdio_oe, sdo;
  int   checks = 0, errors = 0;
  bit   done = 1'b0;
  logic w4_mode = 1'b0;
  logic hdr_oe_any, data_oe_all, data_oe_any;

  spi_cfg_port u_dut (
    .clk_i(clk), .rst_ni(rst_n), .sclk_i(sclk), .cs_ni(cs_n), .sdio_i(sdin),
    .sdio_o(sdio_o), .sdio_oe_o(sdio_oe), .sdo_o(sdo)
  );

  always #2 clk = ~clk;

  // {addr, data}: single-byte MSB-first writes then read-backs
  localparam logic [20:0] VEC [6] = '{
    {13'h0001, 8'hA5}, {13'h0002, 8'h3C}, {13'h0008, 8'hFF},
    {13'h0009, 8'h77}, {13'h1FFF, 8'h12}, {13'h0100, 8'h81}
  };

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk8(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
    end
  endtask

  task automatic chk1(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0b expected %0b", req, what, act, exp);
    end
  endtask

  task automatic cs_drop();
    cs_n = 1'b0; wait_clk(10);
  endtask

  task automatic cs_rise();
    wait_clk(4); cs_n = 1'b1; wait_clk(10);
  endtask

  task automatic bit_xfer(input logic d, input bit in_data, output logic q);
    sdin = d;
    wait_clk(8);
    q = w4_mode ? sdo : sdio_o;
    if (in_data) begin
      data_oe_all &= sdio_oe;
      data_oe_any |= sdio_oe;
    end else hdr_oe_any |= sdio_oe;
    sclk = 1'b1;
    wait_clk(8);
    sclk = 1'b0;
  endtask

  task automatic txn(input bit lsb, input bit rw, input logic [1:0] w, input logic [12:0] a,
                     input int n, input logic [7:0] wd [4], output logic [7:0] rd [4],
                     input int pause_at, input bit hdr_pause);
    logic [15:0] hdr;
    logic q;
    hdr = {rw, w, a};
    hdr_oe_any = 1'b0; data_oe_all = 1'b1; data_oe_any = 1'b0;
    rd = '{default: 8'h00};
    cs_drop();
    for (int i = 0; i < 16; i++) begin
      bit_xfer(hdr[lsb ? i : 15 - i], 1'b0, q);
      if (hdr_pause && i == 7) begin cs_rise(); cs_drop(); end
    end
    for (int k = 0; k < n; k++) begin
      if (pause_at == k) begin cs_rise(); cs_drop(); end
      for (int i = 0; i < 8; i++) begin
        bit_xfer(wd[k][lsb ? i : 7 - i], 1'b1, q);
        rd[k][lsb ? i : 7 - i] = q;
      end
    end
    cs_rise();
  endtask

  task automatic wr(input bit lsb, input logic [12:0] a, input int n, input logic [7:0] d [4]);
    logic [7:0] r [4];
    txn(lsb, 1'b0, (n > 3) ? 2'b11 : 2'(n - 1), a, n, d, r, -1, 1'b0);
  endtask

  task automatic rdb(input bit lsb, input logic [12:0] a, input int n, output logic [7:0] r [4]);
    logic [7:0] z [4];
    z = '{default: 8'h00};
    txn(lsb, 1'b1, (n > 3) ? 2'b11 : 2'(n - 1), a, n, z, r, -1, 1'b0);
  endtask

  initial begin
    wait_clk(150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog (all requirements): actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] r [4];
    logic q;
    wait_clk(5);
    chk1("R1", "oe in reset", sdio_oe, 1'b0);
    rst_n = 1'b1;
    wait_clk(5);

    // R1 reset state
    chk1("R1", "oe after reset", sdio_oe, 1'b0);
    rdb(0, 13'd1, 1, r); chk8("R1", "bank reg after reset", r[0], 8'h00);
    rdb(0, 13'd0, 1, r); chk8("R1", "ctrl after reset", r[0], 8'h00);

    // R2 / R11 vector table
    foreach (VEC[i]) wr(0, VEC[i][20:8], 1, '{VEC[i][7:0], 8'h00, 8'h00, 8'h00});
    foreach (VEC[i]) begin
      logic [12:0] a;
      logic        defd;
      a = VEC[i][20:8];
      defd = (a >= 13'd1 && a <= 13'd8);
      rdb(0, a, 1, r);
      chk8(defd ? "R2" : "R11", "table read", r[0], defd ? VEC[i][7:0] : 8'h00);
    end

    // R3 output enable timing
    rdb(0, 13'd1, 1, r);
    chk8("R3", "read data", r[0], 8'hA5);
    chk1("R3", "oe during header", hdr_oe_any, 1'b0);
    chk1("R3", "oe during read data", data_oe_all, 1'b1);
    chk1("R3", "oe after cs high", sdio_oe, 1'b0);
    wr(0, 13'd3, 1, '{8'h44, 8'h00, 8'h00, 8'h00});
    chk1("R3", "oe during write", data_oe_any, 1'b0);

    // R5 increment with multi-byte write, R9 stream read
    wr(0, 13'd2, 3, '{8'h11, 8'h22, 8'h33, 8'h00});
    rdb(0, 13'd2, 3, r);
    chk8("R5", "incr byte0", r[0], 8'h11);
    chk8("R5", "incr byte1", r[1], 8'h22);
    chk8("R5", "incr byte2", r[2], 8'h33);
    rdb(0, 13'd1, 4, r);
    chk8("R9", "stream read byte0", r[0], 8'hA5);
    chk8("R9", "stream read byte3", r[3], 8'h33);

    // R7 exact length
    wr(0, 13'd7, 1, '{8'h5A, 8'h00, 8'h00, 8'h00});
    wr(0, 13'd5, 2, '{8'h01, 8'h02, 8'h00, 8'h00});
    rdb(0, 13'd5, 3, r);
    chk8("R7", "two-byte write first", r[0], 8'h01);
    chk8("R7", "two-byte write second", r[1], 8'h02);
    chk8("R7", "register past end", r[2], 8'h5A);

    // R8 pause at byte boundary, short transfers
    txn(0, 1'b0, 2'b10, 13'd1, 3, '{8'hC1, 8'hC2, 8'hC3, 8'h00}, r, 2, 1'b0);
    txn(0, 1'b1, 2'b10, 13'd1, 3, '{default: 8'h00}, r, 1, 1'b0);
    chk8("R8", "paused read byte0", r[0], 8'hC1);
    chk8("R8", "paused read byte1", r[1], 8'hC2);
    chk8("R8", "paused read byte2", r[2], 8'hC3);

    // R9 stream with header pause and pause before first byte
    txn(0, 1'b0, 2'b11, 13'd1, 4, '{8'hD1, 8'hD2, 8'hD3, 8'hD4}, r, 0, 1'b1);
    rdb(0, 13'd1, 4, r);
    chk8("R9", "stream write byte0", r[0], 8'hD1);
    chk8("R9", "stream write byte3", r[3], 8'hD4);

    // R9 pause after a streamed byte aborts
    txn(0, 1'b0, 2'b11, 13'd1, 2, '{8'hE1, 8'hE2, 8'h00, 8'h00}, r, -1, 1'b0);
    rdb(0, 13'd3, 1, r);
    chk8("R9", "reg after stream abort", r[0], 8'hD3);
    rdb(0, 13'd1, 2, r);
    chk8("R9", "stream abort byte0", r[0], 8'hE1);
    chk8("R9", "stream abort byte1", r[1], 8'hE2);

    // R10 mid-byte chip-select rise
    hdr_oe_any = 1'b0; data_oe_all = 1'b1; data_oe_any = 1'b0;
    cs_drop();
    for (int i = 0; i < 16; i++) bit_xfer(logic'(16'h0004 >> (15 - i)), 1'b0, q);
    for (int i = 0; i < 4; i++) bit_xfer(1'b1, 1'b1, q);
    cs_rise();
    rdb(0, 13'd4, 1, r);
    chk8("R10", "partial byte not written", r[0], 8'hD4);

    // R12 control write applies next transaction; R4 LSB-first
    wr(0, 13'd0, 2, '{8'h40, 8'h12, 8'h00, 8'h00});
    rdb(1, 13'd0, 1, r); chk8("R4", "ctrl read lsb-first", r[0], 8'h40);
    rdb(1, 13'd1, 1, r); chk8("R12", "same-txn byte kept order", r[0], 8'h12);

    // R5 decrement in LSB-first
    wr(1, 13'd6, 2, '{8'hA1, 8'hB2, 8'h00, 8'h00});
    rdb(1, 13'd6, 2, r);
    chk8("R5", "decr byte0", r[0], 8'hA1);
    chk8("R5", "decr byte1", r[1], 8'hB2);

    // R11 unused control bits
    wr(1, 13'd0, 1, '{8'h4F, 8'h00, 8'h00, 8'h00});
    rdb(1, 13'd0, 1, r); chk8("R11", "ctrl unused bits", r[0], 8'h40);

    // R6 4-wire mode
    wr(1, 13'd0, 1, '{8'hC0, 8'h00, 8'h00, 8'h00});
    w4_mode = 1'b1;
    rdb(1, 13'd6, 1, r);
    chk8("R6", "read on dedicated output", r[0], 8'hA1);
    chk1("R6", "shared line oe in 4-wire", data_oe_any, 1'b0);
    wr(1, 13'd0, 1, '{8'h00, 8'h00, 8'h00, 8'h00});
    w4_mode = 1'b0;
    rdb(0, 13'd6, 1, r);
    chk8("R6", "back to 3-wire msb-first", r[0], 8'hA1);
    chk1("R6", "shared line oe in 3-wire", data_oe_all, 1'b1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule